// File: doc/BRIEF.md
# Table-Driven DMA Channel Scheduler

This block sets the order in which DMA channels get service. Software loads a table of one-byte entries. Each entry names a channel and says whether the slot is for receive or transmit. It then writes a control register that gives the index of the last entry in use and turns the scheduler on. While the scheduler is on, it presents one entry at a time on its slot outputs. When the downstream engine signals that it has finished the slot, the scheduler moves to the next entry. After the last entry it returns to entry 0.

Table words are written through a simple write port. Four entries are packed into each 32-bit word. The presented entry is captured in a register at the moment the scheduler arrives at it. As a result, software can rewrite the table while the scheduler runs, and the slot that is currently shown never changes partway through. The scheduler does not move data, master a bus or handle descriptors.

Top module: `table_sched`

## Requirements
- R1: An entry is one byte. Bits 6:0 carry the channel number, and bit 7 set marks a receive slot. On the ports, slot_chan shows bits 6:0 of the current entry and slot_rx shows bit 7.
- R2: Table word w holds entries 4w through 4w+3. Entry 4w+k sits in bits 8k+7:8k of that word, and a table write (wr_ctrl low) with wr_idx = w replaces all four.
- R3: A control write (wr_ctrl high) does three things. It loads the enable from data bit 31 and the last index from data bits 7:0. It also moves the pointer to entry 0, so that entry 0 is presented from the next cycle onward.
- R4: While the scheduler is disabled, slot_valid, slot_chan and slot_rx are all 0, and table writes leave the outputs unchanged.
- R5: While the scheduler is enabled, a slot_done pulse that is sampled at a clock edge moves the pointer to the following entry. The new entry appears on the outputs in the cycle after that edge. Without slot_done, the outputs hold.
- R6: A slot_done pulse on the entry at the last index wraps the pointer to entry 0, and the pointer never goes past the last index.
- R7: A table write to the word that holds the current entry does not change the slot outputs. The new value is presented the next time that entry is visited.
- R8: After synchronous reset, the scheduler is disabled, the pointer is 0 and every table word is 0.
- R9: With a last index of 0, every slot_done pulse presents entry 0 again.
- R10: While the scheduler is disabled, slot_done is ignored and the pointer is held at 0. Enabling the scheduler again starts at entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ctrl | input | 1 | 1: write the control register, 0: write a table word |
| wr_idx | input | 6 | Table word index (used for table writes only) |
| wr_data | input | 32 | Write data |
| slot_done | input | 1 | Pulse from downstream: current slot has been served |
| slot_valid | output | 1 | Scheduler enabled, slot outputs are meaningful |
| slot_chan | output | 7 | Channel number of the current slot |
| slot_rx | output | 1 | 1 = receive slot, 0 = transmit slot |

## Verification
The assertions check on every cycle that the outputs are zero while idle and that the pointer stays within the last index. They also check that each slot_done pulse moves the pointer by exactly one or wraps it to 0, that a control write restarts at entry 0, and that the slot outputs hold between done pulses even when the table is being written. Only the bench scenarios can show which channel and direction appear in which order. That covers the byte and lane decoding, whether a rewritten entry shows up on its next visit, and the exact wrap sequence for a sixty-entry table and for a one-entry table.

// File: rtl/sched_pkg.sv
package sched_pkg;

    // Entry and word geometry
    localparam int ENTRY_W = 8;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / ENTRY_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int CHAN_W  = ENTRY_W - 1;
    localparam int EN_BIT  = WORD_W - 1;

    // One scheduling slot: direction flag on top, channel below
    typedef struct packed {
        logic              rx;
        logic [CHAN_W-1:0] chan;
    } entry_t;

    localparam entry_t ENTRY_NONE = '{rx: 1'b0, chan: '0};

    // Extract lane k of a packed table word
    function automatic entry_t lane_of(input logic [WORD_W-1:0] word,
                                       input logic [LANE_W-1:0] lane);
        entry_t e;
        e = entry_t'(word[lane*ENTRY_W +: ENTRY_W]);
        return e;
    endfunction

endpackage

// File: rtl/sched_table.sv
module sched_table
    import sched_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int PTR_W  = $clog2(WORDS * LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WIDX_W-1:0] widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ridx,
    output entry_t            rentry
);

    logic [WORD_W-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[w] <= '0;
            end else if (we && (widx == WIDX_W'(w))) begin
                words[w] <= wdata;
            end
        end
    end

    logic [WIDX_W-1:0] rword;
    logic [LANE_W-1:0] rlane;

    always_comb begin
        rword  = ridx[PTR_W-1:LANE_W];
        rlane  = ridx[LANE_W-1:0];
        rentry = lane_of(words[rword], rlane);
    end

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
    import sched_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic              en_q,
    output logic [PTR_W-1:0]  last_q,
    output logic              restart
);

    assign restart = we;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            last_q <= '0;
        end else if (we) begin
            en_q   <= wdata[EN_BIT];
            last_q <= wdata[PTR_W-1:0];
        end
    end

endmodule

// File: rtl/sched_ptr.sv
module sched_ptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             en,
    input  logic             done,
    input  logic [PTR_W-1:0] last,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] nxt,
    output logic             load
);

    logic advance;
    logic at_last;

    always_comb begin
        at_last = (ptr_q == last);
        advance = en && done && !restart;
        load    = restart || advance;
        if (restart || at_last) begin
            nxt = '0;
        end else begin
            nxt = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= nxt;
        end else if (!en) begin
            ptr_q <= '0;
        end
    end

endmodule

// File: rtl/table_sched.sv
module table_sched
    import sched_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int PTR_W  = $clog2(WORDS * LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              slot_done,
    output logic              slot_valid,
    output logic [CHAN_W-1:0] slot_chan,
    output logic              slot_rx
);

    logic             tbl_we;
    logic             ctl_we;
    logic             en_q;
    logic [PTR_W-1:0] last_q;
    logic             restart;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] nxt;
    logic             load;
    entry_t           rd_entry;
    entry_t           cur_q;

    assign tbl_we = wr_en && !wr_ctrl;
    assign ctl_we = wr_en && wr_ctrl;

    sched_table #(.WORDS(WORDS)) u_table (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_we),
        .widx   (wr_idx),
        .wdata  (wr_data),
        .ridx   (nxt),
        .rentry (rd_entry)
    );

    sched_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl_we),
        .wdata   (wr_data),
        .en_q    (en_q),
        .last_q  (last_q),
        .restart (restart)
    );

    sched_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .en      (en_q),
        .done    (slot_done),
        .last    (last_q),
        .ptr_q   (ptr_q),
        .nxt     (nxt),
        .load    (load)
    );

    // Entry captured on arrival; later table writes wait for the next visit
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= ENTRY_NONE;
        end else if (load) begin
            cur_q <= rd_entry;
        end
    end

    always_comb begin
        slot_valid = en_q;
        slot_chan  = en_q ? cur_q.chan : '0;
        slot_rx    = en_q ? cur_q.rx   : 1'b0;
    end

endmodule

// File: rtl/table_sched_chk.sv
module table_sched_chk #(
    parameter int PTR_W  = 8,
    parameter int CHAN_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_ctrl,
    input logic              en_bit,
    input logic              slot_done,
    input logic              slot_valid,
    input logic [CHAN_W-1:0] slot_chan,
    input logic              slot_rx,
    input logic [PTR_W-1:0]  ptr,
    input logic [PTR_W-1:0]  last
);

    logic ctl_w;
    assign ctl_w = wr_en && wr_ctrl;

    p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !slot_valid |-> (slot_chan == '0 && !slot_rx));

    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_w |=> (ptr == '0 && slot_valid == $past(en_bit)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && !slot_done && !ctl_w) |=>
            ($stable(slot_chan) && $stable(slot_rx) && slot_valid));

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && slot_done && !ctl_w && ptr != last) |=>
            (ptr == $past(ptr) + 1'b1));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (slot_valid && slot_done && !ctl_w && ptr == last) |=> (ptr == '0));

    p_bound_r6: assert property (@(posedge clk) disable iff (rst)
        slot_valid |-> (ptr <= last));

    p_off_r10: assert property (@(posedge clk) disable iff (rst)
        (!slot_valid && !ctl_w) |=> (ptr == '0 && !slot_valid));

endmodule

bind table_sched table_sched_chk #(
    .PTR_W  (PTR_W),
    .CHAN_W (sched_pkg::CHAN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_ctrl    (wr_ctrl),
    .en_bit     (wr_data[sched_pkg::EN_BIT]),
    .slot_done  (slot_done),
    .slot_valid (slot_valid),
    .slot_chan  (slot_chan),
    .slot_rx    (slot_rx),
    .ptr        (ptr_q),
    .last       (last_q)
);

// File: tb/tb_table_sched.sv
module tb_table_sched;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;
    localparam int NENT       = WORDS * 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_ctrl = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        slot_done = 1'b0;
    logic        slot_valid;
    logic [6:0]  slot_chan;
    logic        slot_rx;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [7:0] m_tbl [NENT];
    bit         m_en;
    int         m_last;
    int         m_ptr;
    logic [7:0] m_cur;

    always #(CLK_PERIOD / 2) clk = ~clk;

    table_sched #(.WORDS(WORDS)) dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_ctrl    (wr_ctrl),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .slot_done  (slot_done),
        .slot_valid (slot_valid),
        .slot_chan  (slot_chan),
        .slot_rx    (slot_rx)
    );

    function automatic logic [7:0] pat(input int e, input int salt);
        logic [7:0] b;
        b[6:0] = 7'(((e >> 1) * 5 + 3 + salt) % 128);
        b[7]   = e[0];
        return b;
    endfunction

    // One clock: drive inputs, advance model, wait for the edge, release
    task automatic cyc(input bit we, input bit ctl, input int idx,
                       input logic [31:0] d, input bit done);
        wr_en     = we;
        wr_ctrl   = ctl;
        wr_idx    = 6'(idx);
        wr_data   = d;
        slot_done = done;
        if (we && ctl) begin
            m_en   = d[31];
            m_last = int'(d[7:0]);
            m_ptr  = 0;
            m_cur  = m_tbl[0];
        end else begin
            if (m_en && done) begin
                m_ptr = (m_ptr == m_last) ? 0 : m_ptr + 1;
                m_cur = m_tbl[m_ptr];
            end
            if (we) begin
                for (int k = 0; k < 4; k++) m_tbl[idx*4 + k] = d[8*k +: 8];
            end
        end
        if (!m_en) m_ptr = 0;
        @(posedge clk);
        #1;
        wr_en     = 1'b0;
        wr_ctrl   = 1'b0;
        slot_done = 1'b0;
    endtask

    task automatic check(input string tag);
        logic       ev;
        logic [6:0] ec;
        logic       er;
        ev = m_en;
        ec = m_en ? m_cur[6:0] : 7'd0;
        er = m_en ? m_cur[7] : 1'b0;
        n_chk++;
        if (slot_valid !== ev || slot_chan !== ec || slot_rx !== er) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b chan=%0d rx=%0b, expected valid=%0b chan=%0d rx=%0b",
                     tag, slot_valid, slot_chan, slot_rx, ev, ec, er);
        end
    endtask

    task automatic load_table(input int salt);
        for (int w = 0; w < WORDS; w++) begin
            cyc(1'b1, 1'b0, w,
                {pat(4*w+3, salt), pat(4*w+2, salt), pat(4*w+1, salt), pat(4*w, salt)},
                1'b0);
        end
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) m_tbl[i] = 8'h00;
        m_en = 1'b0; m_last = 0; m_ptr = 0; m_cur = 8'h00;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R8: reset state
        check("R8 reset outputs");

        // R4: table writes while disabled leave outputs at zero
        load_table(0);
        check("R4 idle after table load");

        // R3: enable, 60 entries, entry 0 first
        cyc(1'b1, 1'b1, 0, 32'h8000_003B, 1'b0);
        check("R3 start at entry 0");
        // R5 / R1 / R2: walk every entry
        for (int e = 1; e < 60; e++) begin
            cyc(1'b0, 1'b0, 0, 32'h0, 1'b1);
            check((e % 2) ? "R1 rx entry" : "R2 lane decode R5 step");
        end
        cyc(1'b0, 1'b0, 0, 32'h0, 1'b0);
        check("R5 hold without done");
        // R6: wrap
        cyc(1'b0, 1'b0, 0, 32'h0, 1'b1);
        check("R6 wrap to entry 0");

        // R7: rewrite current word while enabled
        cyc(1'b1, 1'b0, 0, 32'hC5A4_9311, 1'b0);
        check("R7 current slot unchanged");
        for (int e = 1; e <= 60; e++) begin
            cyc(1'b0, 1'b0, 0, 32'h0, 1'b1);
            check("R7 new value on next visit");
        end

        // R9: single-entry table
        cyc(1'b1, 1'b1, 0, 32'h8000_0000, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 0, 32'h0, 1'b1);
            check("R9 single entry repeats");
        end

        // R10 / R4: disable, done ignored, re-enable at entry 0
        cyc(1'b1, 1'b1, 0, 32'h8000_003B, 1'b0);
        cyc(1'b0, 1'b0, 0, 32'h0, 1'b1);
        cyc(1'b0, 1'b0, 0, 32'h0, 1'b1);
        cyc(1'b1, 1'b1, 0, 32'h0000_003B, 1'b0);
        check("R4 disabled outputs zero");
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 0, 32'h0, 1'b1);
            check("R10 done ignored while off");
        end
        cyc(1'b1, 1'b0, 0, 32'h1234_5678, 1'b0);
        check("R4 table write while off");
        cyc(1'b1, 1'b1, 0, 32'h8000_003B, 1'b0);
        check("R10 restart at entry 0");

        // Random phase
        load_table(17);
        cyc(1'b1, 1'b1, 0, 32'h8000_00FF, 1'b0);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2) begin
                cyc(1'b1, 1'b1, 0,
                    {($urandom % 8) != 0, 23'd0, 8'($urandom)}, 1'($urandom));
            end else if (r < 15) begin
                cyc(1'b1, 1'b0, int'($urandom % WORDS), $urandom, 1'($urandom));
            end else begin
                cyc(1'b0, 1'b0, 0, 32'h0, 1'($urandom));
            end
            check("R5 R6 R7 random");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule